// File: doc/BRIEF.md
# UART Transmit Queue with Interrupt Flag

The block is the sending half of an asynchronous serial port. A host drops 9-bit words into a four-slot queue with a one-cycle write strobe. Whenever the bit clock ticks and the serializer is free, the oldest queued word is moved into the serializer. The serializer then shifts the word out on a single line that idles high. Each frame has a low start bit, nine data bits least significant first, and a high stop bit. Every bit lasts `DIV` clock cycles, and that timing comes from an internal clock-enable divider that runs only while the transmitter is enabled.

Two status outputs report the state of the block. The first shows that the queue is full. The second shows that the serializer holds nothing. A sticky interrupt flag tells the host it may refill the queue. Under the "each" condition the flag rises on every hand-off. Under the "drain" condition it rises only on the hand-off that leaves the queue empty. The flag also rises when the transmitter is switched on. The host can change the condition at any time, and it clears the flag with a strobe.

Top module: `uart_txq_top`

## Requirements
- R1: After reset, tx_line is 1, tsr_empty is 1, buf_full is 0 and tx_flag is 0.
- R2: Up to 4 words are queued and transmitted in the order they were written. A slot frees in the cycle its word moves to the serializer, so buf_full falls after the first hand-off from a full queue.
- R3: buf_full is 1 exactly while all 4 slots are occupied.
- R4: A write strobe while buf_full is 1 is dropped. The word is never transmitted and the queued words are unchanged.
- R5: With irq_mode = 0 ("each"), tx_flag is set in the cycle after every hand-off from the queue to the serializer.
- R6: With irq_mode = 1 ("drain"), tx_flag is set only after a hand-off that leaves the queue empty. A write accepted in the same cycle counts as not empty.
- R7: tx_flag is set in the cycle after tx_en changes from 0 to 1, whatever irq_mode is.
- R8: tx_flag stays 1 until a flag_clr strobe. If a set event and flag_clr occur in the same cycle, the set wins.
- R9: tsr_empty is 1 exactly while the serializer holds no frame. Its rising edge has no effect on tx_flag.
- R10: Only reset empties the queue. While tx_en is 0, queued words stay queued and nothing is transmitted. Turning tx_en on and off again does not flush them.
- R11: A frame is one 0 start bit, then data bits 0 to 8, then one 1 stop bit. Each bit lasts DIV clock cycles, and tx_line is 1 when idle.
- R12: When a word is waiting as a stop bit ends, the next start bit follows with no idle gap. tsr_empty rises only at the end of a stop bit with the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; also runs the bit-clock divider |
| irq_mode | input | 1 | Flag condition: 0 = every hand-off, 1 = hand-off that empties the queue |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 9 | Word to queue |
| flag_clr | input | 1 | One-cycle strobe that clears tx_flag |
| tx_line | output | 1 | Serial output, idles high |
| buf_full | output | 1 | All queue slots occupied |
| tsr_empty | output | 1 | Serializer holds no frame |
| tx_flag | output | 1 | Sticky transmit interrupt flag |

## Verification
The bench tries four input patterns:
- **Four-word burst while disabled, then enable.** The queue fills and a fifth word arrives. This separates a correct drop from an overwrite or an extra frame. The short enable pulse that follows separates holding the queue from flushing it.
- **Same burst with the "each" condition.** This shows the flag rising on the first hand-off.
- **Three-word burst with the "drain" condition.** The flag is sampled between frames to separate "every move" from "only the emptying move". The same burst tests back-to-back framing: the serializer must stay busy across the frame boundaries and release only after the last stop bit.
- **Flag clear.** Sampling after a clear separates a sticky flag from a pulsed one, and a clear near the end of the last frame shows that the serializer becoming empty raises no interrupt.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    localparam int WORD_W = 9;

    typedef enum logic {
        IRQ_EACH  = 1'b0,
        IRQ_DRAIN = 1'b1
    } irq_mode_e;

endpackage

// File: rtl/uart_txq_baud.sv
module uart_txq_baud #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } baud_t;

    baud_t q, n;

    always_comb begin
        n = q;
        n.tick = 1'b0;
        if (!run) begin
            n.cnt = '0;
        end else if (q.cnt == CW'(DIV - 1)) begin
            n.cnt  = '0;
            n.tick = 1'b1;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tick = q.tick;

    // R11: bit clock pauses entirely while disabled
    a_r11_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

endmodule

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             avail,
    output logic             full,
    output logic             last,
    output logic             accepted
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wptr;
        logic [AW-1:0]               rptr;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t q, n;
    logic  push_ok, pop_ok;

    always_comb begin
        n       = q;
        push_ok = push && (q.cnt != CW'(DEPTH));
        pop_ok  = pop && (q.cnt != '0);
        if (push_ok) begin
            n.mem[q.wptr] = push_data;
            n.wptr = (q.wptr == AW'(DEPTH - 1)) ? '0 : q.wptr + 1'b1;
        end
        if (pop_ok) begin
            n.rptr = (q.rptr == AW'(DEPTH - 1)) ? '0 : q.rptr + 1'b1;
        end
        n.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign head     = q.mem[q.rptr];
    assign avail    = (q.cnt != '0);
    assign full     = (q.cnt == CW'(DEPTH));
    assign last     = (q.cnt == CW'(1));
    assign accepted = push_ok;

    // R2: occupancy never exceeds the slot count
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R4: a write into a full queue leaves it full and its contents untouched
    a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(q.mem)));

endmodule

// File: rtl/uart_txq_shift.sv
module uart_txq_shift #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             avail,
    input  logic [WIDTH-1:0] head,
    output logic             load,
    output logic             line,
    output logic             empty
);
    localparam int FB   = WIDTH + 2;
    localparam int CW   = $clog2(FB);
    localparam int LAST = FB - 1;

    typedef struct packed {
        logic [FB-1:0] frame;
        logic [CW-1:0] cnt;
        logic          busy;
    } shift_t;

    shift_t q, n;

    always_comb begin
        n    = q;
        load = 1'b0;
        if (tick) begin
            if (q.busy) begin
                if (q.cnt == CW'(LAST)) begin
                    if (avail) load = 1'b1;
                    else       n.busy = 1'b0;
                end else begin
                    n.frame = {1'b1, q.frame[FB-1:1]};
                    n.cnt   = q.cnt + 1'b1;
                end
            end else if (avail) begin
                load = 1'b1;
            end
        end
        if (load) begin
            n.frame = {1'b1, head, 1'b0};
            n.cnt   = '0;
            n.busy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= {{FB{1'b1}}, {CW{1'b0}}, 1'b0};
        else        q <= n;
    end

    assign line  = q.busy ? q.frame[0] : 1'b1;
    assign empty = !q.busy;

    // R11: the line only moves on a bit-clock boundary
    a_r11_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line));

    // R12: a waiting word follows the stop bit directly with a start bit
    a_r12_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && q.busy && q.cnt == CW'(LAST) && avail) |=> (!empty && !line));

endmodule

// File: rtl/uart_txq_top.sv
module uart_txq_top
    import uart_txq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = WORD_W,
    parameter int DIV   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             irq_mode,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             flag_clr,
    output logic             tx_line,
    output logic             buf_full,
    output logic             tsr_empty,
    output logic             tx_flag
);
    logic             tick, load, avail, last, accepted;
    logic [WIDTH-1:0] head;

    uart_txq_baud #(.DIV(DIV)) baud_i (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .tick(tick)
    );

    uart_txq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(wr_stb), .push_data(wr_data),
        .pop(load), .head(head), .avail(avail), .full(buf_full),
        .last(last), .accepted(accepted)
    );

    uart_txq_shift #(.WIDTH(WIDTH)) shift_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .avail(avail), .head(head),
        .load(load), .line(tx_line), .empty(tsr_empty)
    );

    typedef struct packed {
        logic flag;
        logic en_prev;
    } irq_t;

    irq_t q, n;
    logic set_ev;

    always_comb begin
        n         = q;
        n.en_prev = tx_en;
        set_ev    = (tx_en && !q.en_prev)
                 || (load && (irq_mode == IRQ_EACH))
                 || (load && (irq_mode == IRQ_DRAIN) && last && !accepted);
        if (set_ev)        n.flag = 1'b1;
        else if (flag_clr) n.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign tx_flag = q.flag;

    // R5: every hand-off raises the flag in "each" mode
    a_r5_each_move: assert property (@(posedge clk) disable iff (!rst_n)
        (load && irq_mode == IRQ_EACH) |=> tx_flag);

    // R8: flag holds until cleared
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flag && !flag_clr) |=> tx_flag);

    // R7: switching the transmitter on raises the flag
    a_r7_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !q.en_prev) |=> tx_flag);

endmodule

// File: tb/uart_txq_top_tb_top.sv
`timescale 1ns/1ps
module uart_txq_top_tb_top;
    localparam int DIV   = 16;
    localparam int FRAME = 11 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       irq_mode = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       flag_clr = 1'b0;
    logic       tx_line, buf_full, tsr_empty, tx_flag;

    int vectors = 0;
    int miscompares = 0;
    int frames = 0;
    int cyc = 0;
    logic [8:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_txq_top #(.DEPTH(4), .WIDTH(9), .DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_mode(irq_mode),
        .wr_stb(wr_stb), .wr_data(wr_data), .flag_clr(flag_clr),
        .tx_line(tx_line), .buf_full(buf_full), .tsr_empty(tsr_empty),
        .tx_flag(tx_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // driver: expected words go into the scoreboard queue
    task automatic write_word(input logic [8:0] w, input bit expect_kept);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = w;
        if (expect_kept) exp_q.push_back(w);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor: decode frames at mid-bit and compare against the queue
    initial begin : monitor
        logic [8:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && tx_line == 1'b0) begin
                repeat (DIV / 2 - 1) @(negedge clk);
                check("R11 start bit", int'(tx_line), 0);
                for (int k = 0; k < 9; k++) begin
                    repeat (DIV) @(negedge clk);
                    got[k] = tx_line;
                end
                repeat (DIV) @(negedge clk);
                check("R11 stop bit", int'(tx_line), 1);
                frames++;
                if (exp_q.size() == 0) begin
                    check("R4 unexpected frame", int'(got), -1);
                end else begin
                    check("R2 frame data in order", int'(got), int'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
    end

    initial begin : stim
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_line", int'(tx_line), 1);
        check("R1 tsr_empty", int'(tsr_empty), 1);
        check("R1 buf_full", int'(buf_full), 0);
        check("R1 tx_flag", int'(tx_flag), 0);

        // fill while disabled, then overflow
        write_word(9'h155, 1'b1);
        write_word(9'h0A3, 1'b1);
        check("R3 not full at 2", int'(buf_full), 0);
        write_word(9'h1FF, 1'b1);
        write_word(9'h001, 1'b1);
        check("R3 full at 4", int'(buf_full), 1);
        write_word(9'h1AA, 1'b0);
        check("R4 full after dropped write", int'(buf_full), 1);
        check("R10 no flag while disabled", int'(tx_flag), 0);

        // short enable pulse: no bit-clock tick, queue must survive
        @(negedge clk); tx_en = 1'b1;
        repeat (2) @(negedge clk); tx_en = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 queue kept after enable toggle", int'(buf_full), 1);
        check("R10 idle line while disabled", int'(tx_line), 1);
        check("R10 serializer idle while disabled", int'(tsr_empty), 1);
        pulse_clear();
        check("R8 clear strobe", int'(tx_flag), 0);

        // enable in "each" mode
        irq_mode = 1'b0;
        @(negedge clk); tx_en = 1'b1;
        @(negedge clk);
        check("R7 flag on enable", int'(tx_flag), 1);
        pulse_clear();
        check("R8 clear after enable", int'(tx_flag), 0);
        while (tsr_empty) @(negedge clk);
        t0 = cyc;
        repeat (2) @(negedge clk);
        check("R5 flag on first hand-off", int'(tx_flag), 1);
        check("R2 slot freed on hand-off", int'(buf_full), 0);
        wait_until(t0 + 3 * FRAME + 100);
        pulse_clear();
        while (!tsr_empty) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R9 serializer empty raises no flag", int'(tx_flag), 0);
        repeat (300) @(negedge clk);
        check("R4 dropped word never sent", frames, 4);
        check("R2 scoreboard drained", exp_q.size(), 0);

        // "drain" mode, three-word burst
        irq_mode = 1'b1;
        write_word(9'h12C, 1'b1);
        write_word(9'h0F0, 1'b1);
        write_word(9'h107, 1'b1);
        while (tsr_empty) @(negedge clk);
        t0 = cyc;
        wait_until(t0 + 2);
        pulse_clear();
        wait_until(t0 + 100);
        check("R6 no flag after first move", int'(tx_flag), 0);
        wait_until(t0 + FRAME + 100);
        check("R6 no flag after second move", int'(tx_flag), 0);
        check("R12 busy across frame boundary", int'(tsr_empty), 0);
        wait_until(t0 + 2 * FRAME + 100);
        check("R6 flag after emptying move", int'(tx_flag), 1);
        wait_until(t0 + 3 * FRAME - 3);
        check("R12 busy until last stop ends", int'(tsr_empty), 0);
        wait_until(t0 + 3 * FRAME + 3);
        check("R12 empty after last stop", int'(tsr_empty), 1);
        check("R11 idle high after frames", int'(tx_line), 1);

        // stickiness
        repeat (50) @(negedge clk);
        check("R8 flag stays set", int'(tx_flag), 1);
        pulse_clear();
        check("R8 flag cleared", int'(tx_flag), 0);
        repeat (200) @(negedge clk);
        check("R2 all frames seen", frames, 7);
        check("R2 scoreboard empty", exp_q.size(), 0);
        summary();
    end
endmodule